// File: doc/BRIEF.md
# Per-CPU Interrupt Request Interface

This block sits between an interrupt distributor and the active-low interrupt input of one processor. The distributor presents, for every interrupt ID, a pending flag (already filtered for enable and routing to this processor) and a priority value. The interface picks the best candidate and raises the processor's request line when that candidate clears a programmable priority threshold. It only does so when the interface is enabled and no interrupt is currently being serviced.

Software uses a small register window. It programs the threshold while the interface is disabled, then turns the interface on. When the request line is driven low, software reads an acknowledge register to learn which ID to service. When finished, it writes that ID to an end-of-interrupt register so that the next candidate can be signalled. Only one interrupt can be in service at a time. No preemption is performed.

Top module: `cpu_irq_port`

## Requirements
- R1: After reset, `irq_n` is 1, the control register reads 0, the threshold register reads 0 and no interrupt is in service.
- R2: The control register is at offset 0x00. Bits [1:0] are stored and read back. Bit 0 set allows signalling: with bit 0 clear, `irq_n` stays 1 and an acknowledge read returns 1023.
- R3: The threshold register is at offset 0x04 and holds a PRIO_W-bit value in its low bits. A write to it while control bit 0 is set leaves it unchanged.
- R4: The candidate is the pending ID with the numerically smallest priority, where a smaller value means more urgent. Among equal priorities the lower ID wins. The choice is made from the inputs present at the clock edge concerned.
- R5: A candidate is signalled only if its priority is strictly less than the threshold. All ones therefore passes every priority except all ones.
- R6: `irq_n` is a register. It is driven to 0 on the first clock edge at which a qualifying candidate exists, and returns to 1 on the first edge at which none exists.
- R7: A read at offset 0x0C returns the qualifying candidate's ID in bits [9:0] and puts that ID in service. If nothing qualifies, the read returns 1023 and changes nothing. Read data appears on the edge that samples the read.
- R8: While an ID is in service, `irq_n` is 1 on the following edges and acknowledge reads return 1023.
- R9: A write at offset 0x10 releases the ID in service only if the write data equals that ID, with bits above [9:0] zero. Any other value is ignored. The same interrupt may be signalled again after release.
- R10: A read at any offset other than 0x00, 0x04 and 0x0C returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_pend | input | NUM_IRQ | Pending flag per interrupt ID from the distributor |
| src_prio | input | NUM_IRQ*PRIO_W | Priority per ID; ID i occupies bits [i*PRIO_W +: PRIO_W] |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |
| irq_n | output | 1 | Interrupt request to the processor, active low |

## Verification
Two events can fall in the same cycle: the acknowledge read, and a change in the distributor's pending and priority inputs. The acknowledge must return the candidate that the new inputs select, not the candidate that was driving the request line. The bench provokes this by raising a more urgent interrupt on the same clock edge that samples the acknowledge read. It then judges the returned ID against a selection it computes itself from the new inputs. The bench also sweeps every threshold value against a series of generated pending and priority patterns. For each one it predicts the request line, the acknowledge result and the release behaviour arithmetically.

// File: rtl/cpu_irq_port.sv
module cpu_irq_port #(
  parameter int NUM_IRQ = 32,
  parameter int PRIO_W  = 8,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int ID_W    = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_IRQ-1:0]        src_pend,
  input  logic [NUM_IRQ*PRIO_W-1:0] src_prio,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [DATA_W-1:0]         bus_wdata,
  output logic [DATA_W-1:0]         bus_rdata,
  output logic                      irq_n
);

  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFS_ACK  = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] OFS_EOI  = ADDR_W'(8'h10);
  localparam logic [ID_W-1:0]   NO_ID    = '1;

  logic [1:0]        ctrl_q;
  logic [PRIO_W-1:0] mask_q;
  logic              act_q;
  logic [ID_W-1:0]   act_id_q;
  logic [DATA_W-1:0] rdata_q;
  logic              irq_n_q;

  logic              best_hit;
  logic [ID_W-1:0]   best_id;
  logic [PRIO_W-1:0] best_prio;
  logic [DATA_W-1:0] rd_mux;

  wire en       = ctrl_q[0];
  wire qualify  = en && !act_q && best_hit && (best_prio < mask_q);
  wire wr_ctrl  = bus_wr && (bus_addr == OFS_CTRL);
  wire wr_mask  = bus_wr && (bus_addr == OFS_MASK) && !en;
  wire eoi_ok   = (bus_wdata == DATA_W'(act_id_q));
  wire wr_eoi   = bus_wr && (bus_addr == OFS_EOI) && act_q && eoi_ok;
  wire rd_ack   = bus_rd && (bus_addr == OFS_ACK);
  wire take     = rd_ack && qualify;

  always_comb begin
    best_hit  = 1'b0;
    best_id   = '0;
    best_prio = '1;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (src_pend[i] && (!best_hit || src_prio[i*PRIO_W +: PRIO_W] < best_prio)) begin
        best_hit  = 1'b1;
        best_id   = ID_W'(i);
        best_prio = src_prio[i*PRIO_W +: PRIO_W];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      OFS_CTRL: rd_mux = DATA_W'(ctrl_q);
      OFS_MASK: rd_mux = DATA_W'(mask_q);
      OFS_ACK:  rd_mux = take ? DATA_W'(best_id) : DATA_W'(NO_ID);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      mask_q   <= '0;
      act_q    <= 1'b0;
      act_id_q <= '0;
      rdata_q  <= '0;
      irq_n_q  <= 1'b1;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata[1:0];
      if (wr_mask) mask_q <= bus_wdata[PRIO_W-1:0];
      if (take) begin
        act_q    <= 1'b1;
        act_id_q <= best_id;
      end else if (wr_eoi) begin
        act_q    <= 1'b0;
      end
      if (bus_rd) rdata_q <= rd_mux;
      irq_n_q <= !qualify;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_n     = irq_n_q;

endmodule

// File: rtl/cpu_irq_port_chk.sv
module cpu_irq_port_chk #(
  parameter int ADDR_W = 8,
  parameter int ID_W   = 10,
  parameter int PRIO_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_n,
  input logic              en,
  input logic              act,
  input logic [ID_W-1:0]   act_id,
  input logic [PRIO_W-1:0] mask,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [ID_W-1:0]   bus_wdata_id
);

  localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFS_ACK  = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] OFS_EOI  = ADDR_W'(8'h10);

  // R2
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> irq_n);

  // R8
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act |=> irq_n);

  // R3
  mask_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && bus_wr && bus_addr == OFS_MASK) |=> $stable(mask));

  // R7
  ack_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act) |-> $past(bus_rd && bus_addr == OFS_ACK));

  // R9
  eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act) |-> $past(bus_wr && bus_addr == OFS_EOI && bus_wdata_id == act_id));

endmodule

bind cpu_irq_port cpu_irq_port_chk #(
  .ADDR_W(ADDR_W), .ID_W(ID_W), .PRIO_W(PRIO_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .en(ctrl_q[0]), .act(act_q),
  .act_id(act_id_q), .mask(mask_q), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata_id(bus_wdata[ID_W-1:0])
);

// File: tb/cpu_irq_port_tb_top.sv
`timescale 1ns/1ps
module cpu_irq_port_tb_top;
  localparam int N  = 8;
  localparam int PW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src_pend = '0;
  logic [N*PW-1:0] src_prio = '0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq_n;

  int checks = 0, errors = 0;
  bit done = 0;

  cpu_irq_port #(.NUM_IRQ(N), .PRIO_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_pend(src_pend), .src_prio(src_prio),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n));

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic int best_of(input logic [N-1:0] p, input logic [N*PW-1:0] pr, output int bp);
    int id = -1;
    bp = 1 << PW;
    for (int i = 0; i < N; i++)
      if (p[i] && int'(pr[i*PW +: PW]) < bp) begin
        id = i; bp = int'(pr[i*PW +: PW]);
      end
    return id;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] s = 32'h1234_5678;
    int bid, bp;
    bit q;
    repeat (3) @(negedge clk);
    chk("R1 irq_n in reset", {31'b0, irq_n}, 1);
    rst_n = 1'b1;
    settle();
    chk("R1 irq_n after reset", {31'b0, irq_n}, 1);
    rd(8'h00, d); chk("R1 ctrl reset", d, 0);
    rd(8'h04, d); chk("R1 mask reset", d, 0);
    rd(8'h0C, d); chk("R1 ack after reset", d, 1023);

    // R10 unmapped offsets
    rd(8'h08, d); chk("R10 offset 0x08", d, 0);
    rd(8'h10, d); chk("R10 offset 0x10", d, 0);

    // R2 disabled interface is silent
    src_pend = 8'h01; src_prio = '0;
    wr(8'h04, 7);
    settle(); settle();
    chk("R2 disabled irq_n", {31'b0, irq_n}, 1);
    rd(8'h0C, d); chk("R2 disabled ack", d, 1023);
    wr(8'h00, 3);
    rd(8'h00, d); chk("R2 ctrl readback", d, 3);

    // R3 mask locked while enabled
    wr(8'h04, 2);
    rd(8'h04, d); chk("R3 mask write ignored", d, 7);
    wr(8'h00, 0);
    src_pend = '0;

    // R4 tie toward lower id
    src_prio = {8{3'd4}};
    src_pend = 8'b0011_0100;
    wr(8'h00, 1);
    settle();
    chk("R4 tie irq_n", {31'b0, irq_n}, 0);
    rd(8'h0C, d); chk("R4 tie picks lower id", d, 2);
    wr(8'h10, 2);
    wr(8'h00, 0);

    // R4 selection follows inputs present at the acknowledge edge
    src_prio = '0; src_prio[5*PW +: PW] = 3'd3; src_prio[6*PW +: PW] = 3'd1;
    src_pend = 8'b0010_0000;
    wr(8'h00, 1);
    settle();
    chk("R4 single source irq_n", {31'b0, irq_n}, 0);
    @(negedge clk);
    src_pend = 8'b0110_0000; bus_rd = 1'b1; bus_addr = 8'h0C;
    @(negedge clk);
    bus_rd = 1'b0;
    chk("R4 ack same edge as new source", bus_rdata, 6);
    wr(8'h10, 6);
    wr(8'h00, 0);

    // Sweep: patterns x every threshold
    for (int pat = 0; pat < 40; pat++) begin
      s ^= s << 13; s ^= s >> 17; s ^= s << 5;
      src_pend = s[7:0];
      s ^= s << 13; s ^= s >> 17; s ^= s << 5;
      src_prio = s[N*PW-1:0];
      bid = best_of(src_pend, src_prio, bp);
      for (int m = 0; m < (1 << PW); m++) begin
        wr(8'h00, 0);
        wr(8'h04, m);
        wr(8'h00, 3);
        settle();
        q = (bid >= 0) && (bp < m);
        chk("R5 R6 irq_n vs threshold", {31'b0, irq_n}, q ? 0 : 1);
        rd(8'h0C, d);
        chk("R7 ack id", d, q ? bid : 1023);
        if (q) begin
          settle();
          chk("R8 irq_n while in service", {31'b0, irq_n}, 1);
          rd(8'h0C, d);
          chk("R8 ack while in service", d, 1023);
          wr(8'h10, bid ^ 1);
          settle();
          chk("R9 wrong id ignored", {31'b0, irq_n}, 1);
          wr(8'h10, 32'h400 | bid);
          settle();
          chk("R9 upper bits set ignored", {31'b0, irq_n}, 1);
          wr(8'h10, bid);
          settle();
          chk("R9 release re-signals", {31'b0, irq_n}, 0);
          rd(8'h0C, d);
          chk("R9 ack after release", d, bid);
          wr(8'h10, bid);
        end
      end
    end
    wr(8'h00, 0);

    // R6 drop of pending source clears the request
    src_pend = 8'h01; src_prio = '0;
    wr(8'h04, 7);
    wr(8'h00, 1);
    settle();
    chk("R6 request asserted", {31'b0, irq_n}, 0);
    @(negedge clk); src_pend = '0;
    @(negedge clk);
    chk("R6 request released", {31'b0, irq_n}, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule